// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers single-cycle event pulses from a network controller into sticky status flags, one per event source. Software reads the flags through a small register port and acknowledges each one by writing a 1 to its bit position. A mask register keeps chosen flags out of the interrupt summary while they go on recording events.

A read-only summary bit is set whenever any unmasked flag is pending. The active-low interrupt pin is driven from a register. It asserts only when the global enable is on and an unmasked flag is pending. Some flag positions, chosen by the parameter `GATED_FLAGS` (default `16'hF000`), also need their own enable bit before they can drive the pin.

The register port has four locations, selected by a 2-bit address:
- 0: status (write 1 to clear)
- 1: mask
- 2: per-flag enable
- 3: control (bit 0 global enable, bit 1 soft reset, bit 15 summary)

Top module: `irq_status_agg`

## Requirements
- R1: An event pulse on `evt_i[i]` sets status flag i at the next clock edge. The flag stays set until software or reset clears it.
- R2: A write to address 0 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R3: Mask register (address 1) bit i = 1 removes flag i from the summary. Flag i still records events and still reads back in the status register.
- R4: The summary is high exactly when some flag is set and its mask bit is 0. It appears on `irq_summary_o` and at control bit 15 in the same cycle as the flag state. Writes to control bit 15 have no effect.
- R5: `irq_n_o` is low only when control bit 0 (global enable) is 1 and a contributing flag is pending. The pin is registered, so it reflects the flag, mask, enable and control state of the previous cycle.
- R6: A flag in `GATED_FLAGS` contributes to the pin only when its enable bit (address 2) is 1. Enable bits for the other positions read 0, and those flags need no enable.
- R7: Hardware reset (`rst_n` low) clears flags, masks, enables and the global enable, and drives `irq_n_o` high.
- R8: If an event and a write-1 clear hit the same flag in the same cycle, the flag is set after the edge.
- R9: Writing 1 to control bit 1 clears flags, masks, enables and the global enable at the next edge. This soft reset takes precedence over events in the same cycle, and the bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| evt_i | input | N_FLAGS | Event pulses, one per flag |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data of the selected register |
| irq_summary_o | output | 1 | Summary of unmasked pending flags |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
Flag, mask, enable and control updates are due one edge after the event or write that causes them. The summary and the read data follow that state in the same cycle, with no added edge. The pin lags by a second edge. The bench drives inputs on the falling edge and keeps a cycle model that advances once per rising edge. It samples on the next falling edge, so reads and the summary are compared against the state just written. The pin is compared against the expected value from one step earlier, and dedicated checks confirm that the pin has not yet moved one edge after an event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_ENABLE = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_GIE_BIT   = 0;
  localparam int CTRL_SWRST_BIT = 1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_FLAGS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] evt_i,
  input  logic [N_FLAGS-1:0] clr_i,
  input  logic               sw_rst_i,
  output logic [N_FLAGS-1:0] flags_o,
  output logic [N_FLAGS-1:0] clr_blocked_o
);
  // next value of one sticky bit: a set beats a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // clears that lose against an event in the same cycle
  assign clr_blocked_o = clr_i & evt_i;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[i] <= 1'b0;
      else if (sw_rst_i) flags_o[i] <= 1'b0;
      else               flags_o[i] <= sticky_next(flags_o[i], evt_i[i], clr_i[i]);
    end
  end

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst_i |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
  // R1
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(evt_i)) == '0));
  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst_i |=> ((flags_o & $past(clr_i & ~evt_i)) == '0));
  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_blocked_o) && !sw_rst_i) |=> ((flags_o & $past(clr_blocked_o)) == $past(clr_blocked_o)));
  // R9
  swrst_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (flags_o == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int                 N_FLAGS     = 16,
  parameter int                 DATA_W      = 16,
  parameter logic [N_FLAGS-1:0] GATED_FLAGS = 16'hF000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask_i,
  input  logic               wr_en_i,
  input  logic               wr_ctrl_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [N_FLAGS-1:0] mask_o,
  output logic [N_FLAGS-1:0] en_o,
  output logic               gie_o,
  output logic               sw_rst_o
);
  // soft reset is a strobe, never stored
  assign sw_rst_o = wr_ctrl_i & wdata_i[CTRL_SWRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (sw_rst_o)  mask_o <= '0;
    else if (wr_mask_i) mask_o <= wdata_i[N_FLAGS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gie_o <= 1'b0;
    else if (sw_rst_o)  gie_o <= 1'b0;
    else if (wr_ctrl_i) gie_o <= wdata_i[CTRL_GIE_BIT];
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_en
    if (GATED_FLAGS[i]) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        en_o[i] <= 1'b0;
        else if (sw_rst_o) en_o[i] <= 1'b0;
        else if (wr_en_i)  en_o[i] <= wdata_i[i];
      end
    end else begin : g_none
      assign en_o[i] = 1'b0;
    end
  end

  // R3
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask_i && !sw_rst_o) |=> (mask_o == $past(wdata_i[N_FLAGS-1:0])));
  // R9
  swrst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |=> (mask_o == '0 && en_o == '0 && !gie_o));
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int                 N_FLAGS     = 16,
  parameter logic [N_FLAGS-1:0] GATED_FLAGS = 16'hF000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic [N_FLAGS-1:0] mask_i,
  input  logic [N_FLAGS-1:0] en_i,
  input  logic               gie_i,
  output logic               summary_o,
  output logic [N_FLAGS-1:0] pin_src_o,
  output logic               irq_n_o
);
  function automatic logic [N_FLAGS-1:0] unmasked(input logic [N_FLAGS-1:0] f, input logic [N_FLAGS-1:0] m);
    return f & ~m;
  endfunction

  function automatic logic [N_FLAGS-1:0] pin_sources(input logic [N_FLAGS-1:0] f,
      input logic [N_FLAGS-1:0] m, input logic [N_FLAGS-1:0] e);
    return unmasked(f, m) & (~GATED_FLAGS | e);
  endfunction

  assign summary_o = |unmasked(flags_i, mask_i);
  assign pin_src_o = pin_sources(flags_i, mask_i, en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~(gie_i & (|pin_src_o));
  end

  // R5
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> $past(gie_i && summary_o));
  // R6
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags_i & ~mask_i & ~GATED_FLAGS) == '0) && ((flags_i & ~mask_i & en_i) == '0)) |=> irq_n_o);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int                 N_FLAGS     = 16,
  parameter int                 DATA_W      = 16,
  parameter logic [N_FLAGS-1:0] GATED_FLAGS = 16'hF000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] evt_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_summary_o,
  output logic               irq_n_o
);
  localparam int SUM_BIT = DATA_W - 1;

  logic               wr_status, wr_mask, wr_en, wr_ctrl;
  logic [N_FLAGS-1:0] clr_req, flags, mask, en, clr_blocked, pin_src;
  logic               gie, sw_rst;

  assign wr_status = reg_wr_i && (reg_addr_i == REG_STATUS);
  assign wr_mask   = reg_wr_i && (reg_addr_i == REG_MASK);
  assign wr_en     = reg_wr_i && (reg_addr_i == REG_ENABLE);
  assign wr_ctrl   = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign clr_req   = wr_status ? reg_wdata_i[N_FLAGS-1:0] : '0;

  irq_flag_bank #(.N_FLAGS(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_req), .sw_rst_i(sw_rst),
    .flags_o(flags), .clr_blocked_o(clr_blocked)
  );

  irq_cfg_regs #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W), .GATED_FLAGS(GATED_FLAGS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_mask_i(wr_mask), .wr_en_i(wr_en), .wr_ctrl_i(wr_ctrl),
    .wdata_i(reg_wdata_i), .mask_o(mask), .en_o(en), .gie_o(gie), .sw_rst_o(sw_rst)
  );

  irq_pin_gen #(.N_FLAGS(N_FLAGS), .GATED_FLAGS(GATED_FLAGS)) u_pin (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .mask_i(mask), .en_i(en), .gie_i(gie),
    .summary_o(irq_summary_o), .pin_src_o(pin_src), .irq_n_o(irq_n_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_e'(reg_addr_i))
      REG_STATUS: reg_rdata_o[N_FLAGS-1:0] = flags;
      REG_MASK:   reg_rdata_o[N_FLAGS-1:0] = mask;
      REG_ENABLE: reg_rdata_o[N_FLAGS-1:0] = en;
      REG_CTRL: begin
        reg_rdata_o[CTRL_GIE_BIT] = gie;
        reg_rdata_o[SUM_BIT]      = irq_summary_o;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  // R4
  summary_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_summary_o) |-> $past(reg_wr_i && (reg_addr_i != REG_ENABLE)));
  // R8
  blocked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(clr_blocked & ~mask)) && !sw_rst) |=> irq_summary_o);
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
  localparam logic [15:0] GATED_B = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] b_evt = '0;
  logic [1:0]  b_addr = '0;
  logic        b_wr = 1'b0;
  logic [15:0] b_wdata = '0;
  logic [15:0] rdata;
  logic        summary, irq_n;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_flags = '0, m_mask = '0, m_en = '0;
  logic        m_gie = 1'b0, m_pin = 1'b1;
  logic [31:0] lf = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  irq_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(b_evt), .reg_addr_i(b_addr), .reg_wr_i(b_wr),
    .reg_wdata_i(b_wdata), .reg_rdata_o(rdata), .irq_summary_o(summary), .irq_n_o(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic exp_summary();
    logic s = 1'b0;
    for (int i = 0; i < 16; i++) if (m_flags[i] && !m_mask[i]) s = 1'b1;
    return s;
  endfunction

  function automatic logic exp_pin_low();
    logic p = 1'b0;
    for (int i = 0; i < 16; i++)
      if (m_flags[i] && !m_mask[i] && (!GATED_B[i] || m_en[i])) p = 1'b1;
    return p && m_gie;
  endfunction

  // one rising edge; model advances, outputs compared at the falling edge
  task automatic step();
    logic swr;
    logic [15:0] nf;
    logic np;
    np  = ~exp_pin_low();
    swr = b_wr && b_addr == 2'd3 && b_wdata[1];
    for (int i = 0; i < 16; i++) begin
      if (swr) nf[i] = 1'b0;
      else if (b_evt[i]) nf[i] = 1'b1;
      else if (b_wr && b_addr == 2'd0 && b_wdata[i]) nf[i] = 1'b0;
      else nf[i] = m_flags[i];
    end
    @(posedge clk);
    m_flags = nf;
    m_pin = np;
    if (swr) begin
      m_mask = '0; m_en = '0; m_gie = 1'b0;
    end else if (b_wr) begin
      if (b_addr == 2'd1) m_mask = b_wdata;
      if (b_addr == 2'd2) m_en = b_wdata & GATED_B;
      if (b_addr == 2'd3) m_gie = b_wdata[0];
    end
    @(negedge clk);
    b_evt = '0;
    b_wr = 1'b0;
    chk("R4 summary follows unmasked flags", 32'(summary), 32'(exp_summary()));
    chk("R5 pin one cycle after state", 32'(irq_n), 32'(m_pin));
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    step();
  endtask

  task automatic pulse(input logic [15:0] e);
    b_evt = e;
    step();
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    b_addr = a;
    #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 16'h0000, "R7 status after reset");
    chk("R7 pin high in reset", 32'(irq_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(2'd0, 16'h0000, "R7 status cleared");
    rd_chk(2'd1, 16'h0000, "R7 mask cleared");
    rd_chk(2'd2, 16'h0000, "R7 enable cleared");
    rd_chk(2'd3, 16'h0000, "R7 control cleared");
    chk("R7 pin high", 32'(irq_n), 32'd1);

    wr(2'd3, 16'h0001);
    wr(2'd2, 16'hFFFF);
    rd_chk(2'd2, GATED_B, "R6 ungated enable bits read 0");

    for (int i = 0; i < 16; i++) begin
      pulse(16'(1 << i));
      rd_chk(2'd0, 16'(1 << i), "R1 event sets flag");
      chk("R5 pin not yet low one edge after event", 32'(irq_n), 32'd1);
      step();
      chk("R5 pin low two edges after event", 32'(irq_n), 32'd0);
      rd_chk(2'd0, 16'(1 << i), "R1 flag held");
      wr(2'd0, ~16'(1 << i));
      rd_chk(2'd0, 16'(1 << i), "R2 zero bits leave flag");
      wr(2'd0, 16'(1 << i));
      rd_chk(2'd0, 16'h0000, "R2 one bit clears flag");
      step();
    end

    pulse(16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      wr(2'd1, ~16'(1 << i));
      chk("R3 single unmasked flag raises summary", 32'(summary), 32'd1);
    end
    wr(2'd1, 16'hFFFF);
    chk("R3 all masked summary low", 32'(summary), 32'd0);
    rd_chk(2'd0, 16'hFFFF, "R3 masked flags still recorded");
    rd_chk(2'd3, 16'h0001, "R4 control summary bit low");
    step();
    chk("R3 masked flags keep pin high", 32'(irq_n), 32'd1);

    wr(2'd1, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 16'(1 << i));
      chk("R4 summary until last flag cleared", 32'(summary), 32'(i < 15));
      rd_chk(2'd3, (i < 15) ? 16'h8001 : 16'h0001, "R4 control summary bit");
    end
    wr(2'd3, 16'h8001);
    rd_chk(2'd3, 16'h0001, "R4 summary bit read-only");

    pulse(16'h0001);
    wr(2'd3, 16'h0000);
    step();
    chk("R5 global enable off keeps pin high", 32'(irq_n), 32'd1);
    chk("R5 summary independent of enable", 32'(summary), 32'd1);
    wr(2'd3, 16'h0001);
    step();
    chk("R5 global enable on drives pin low", 32'(irq_n), 32'd0);
    wr(2'd0, 16'hFFFF);

    wr(2'd2, 16'h0000);
    pulse(16'h1000);
    step();
    chk("R6 gated flag without enable keeps pin high", 32'(irq_n), 32'd1);
    chk("R6 gated flag still in summary", 32'(summary), 32'd1);
    wr(2'd2, 16'h1000);
    step();
    chk("R6 gated flag with enable drives pin", 32'(irq_n), 32'd0);
    wr(2'd0, 16'hFFFF);

    pulse(16'h0060);
    b_evt = 16'h0020;
    wr(2'd0, 16'h0060);
    rd_chk(2'd0, 16'h0020, "R8 event beats clear");

    wr(2'd1, 16'h00F0);
    wr(2'd2, 16'hF000);
    pulse(16'h0F0F);
    b_evt = 16'h00FF;
    wr(2'd3, 16'h0003);
    rd_chk(2'd0, 16'h0000, "R9 soft reset clears flags over events");
    rd_chk(2'd1, 16'h0000, "R9 soft reset clears mask");
    rd_chk(2'd2, 16'h0000, "R9 soft reset clears enables");
    rd_chk(2'd3, 16'h0000, "R9 soft reset clears global enable");
    step();

    wr(2'd3, 16'h0001);
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b_evt = lf[15:0] & lf[31:16] & {16{lf[4]}};
      if (lf[7:5] == 3'd0) begin
        b_addr = lf[9:8];
        b_wdata = lf[31:16];
        if (lf[9:8] == 2'd3 && lf[11:10] != 2'd0) b_wdata[1] = 1'b0;
        b_wr = 1'b1;
      end
      step();
      rd_chk(2'd0, m_flags, "R1 R2 R8 random status");
      rd_chk(2'd1, m_mask, "R3 random mask");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule